// File: doc/BRIEF.md
# Data-Strobe Serial Link Codec

This block sits between a parallel link-side bus and one serial port built from two line pairs. One fast clock drives it. A system tick, one fast cycle in every eight, stands in for the link-side system clock. A bit slot enable derived from the fast clock stands in for the serial bit clock. At the top speed one bit moves per fast cycle, at the middle speed one bit moves every second cycle, and at the low speed one bit moves every fourth cycle. At each system tick the link side therefore exchanges 8, 4 or 2 bits.

On transmit, the block samples a word at every system tick and shifts its bits out most-significant first. Data goes on the B line and strobe goes on the A line. The strobe changes only when a bit repeats the previous bit, so exactly one of the two lines moves in every bit slot.

On receive, the line roles are swapped: data arrives on the A line and strobe on the B line. The block marks a new bit whenever the XOR of the two lines changes, and takes the data line at that moment. It packs the bits into words and hands each word through a two-entry buffer to the system tick. The speed is captured when a packet starts and held until it ends. Receive and transmit exclude one another.

Top module: `ds_link`

## Requirements
- R1: Speed codes are 2 (top), 1 (middle) and 0 or 3 (low). While transmitting, each system tick takes the low W bits of `tx_data_i`, with W = 8, 4 or 2 for those codes. Every sampled bit is sent exactly once and no extra bits are sent.
- R2: Within a word, bits leave most-significant first, and the data bit is driven on `tpb_o`.
- R3: The strobe is driven on `tpa_o` and changes in a bit slot exactly when that bit equals the previous bit. At packet start the previous bit and the strobe are both taken as 0. While driving, the two lines never change in the same cycle.
- R4: Bits are spaced 8/W fast cycles apart. The first bit of a word appears 8/W fast cycles after the edge that sampled it.
- R5: `tx_drive_o` rises at the edge that samples the first word. It stays high for one system period after the last word. Both transmit lines read 0 whenever it is low.
- R6: The transmit speed is captured at packet start. Changes on `spd_i` during the packet have no effect.
- R7: On receive, data comes from `tpa_i` and strobe from `tpb_i`. A bit is taken at each change of their XOR. W bits are packed most-significant first into the low bits of `rx_word_o`, and the upper bits are 0.
- R8: `rx_valid_o` and `rx_word_o` change only at system tick edges. Each received word is presented for exactly one system period, in arrival order.
- R9: The receive speed is captured when `rx_en_i` rises. Later changes on `spd_i` have no effect on that reception.
- R10: While `rx_en_i` is high or a reception is active, no transmit packet starts and `tx_drive_o` stays low.
- R11: Line activity while `rx_en_i` is low produces no word. A partial word left when reception ends is discarded.
- R12: After reset all outputs are low, and `sys_tick_o` is high for one fast cycle in every eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| spd_i | input | 2 | Speed code: 0 low, 1 middle, 2 top |
| tx_en_i | input | 1 | Transmit request, sampled at system ticks |
| tx_data_i | input | 8 | Parallel transmit word, low W bits used |
| tx_drive_o | output | 1 | Transmit lines enabled |
| tpa_o | output | 1 | A line out: strobe |
| tpb_o | output | 1 | B line out: data |
| rx_en_i | input | 1 | Receive mode request |
| tpa_i | input | 1 | A line in: data |
| tpb_i | input | 1 | B line in: strobe |
| rx_valid_o | output | 1 | Received word valid for this system period |
| rx_word_o | output | 8 | Received word, low W bits |
| sys_tick_o | output | 1 | System clock tick, one cycle in eight |

## Verification
A transmit word is sampled at the edge that ends a `sys_tick_o` cycle. Its first bit shows on the lines 1, 2 or 4 fast cycles later, and each later bit follows the same spacing. The bench therefore drives inputs at the falling edge inside the tick cycle and measures the distance between line transitions at falling edges. A received bit reaches the packer two edges after the line change, because the line is registered once and then compared. A word is held in the buffer until the next tick edge, and then it stays on `rx_word_o` for a whole system period. The receive monitor samples at the falling edge within each tick cycle, so every presented word is seen exactly once. The expected bits and words are queued by the drivers from the requirements.

// File: rtl/ds_link_pkg.sv
package ds_link_pkg;

    localparam int unsigned DS_WMAX = 8;
    localparam int unsigned DS_PH_W = $clog2(DS_WMAX);
    localparam int unsigned DS_CNT_W = $clog2(DS_WMAX + 1);

    typedef enum logic [1:0] {
        SPD_LOW  = 2'd0,
        SPD_MID  = 2'd1,
        SPD_HIGH = 2'd2,
        SPD_RSVD = 2'd3
    } ds_speed_e;

    typedef logic [DS_WMAX-1:0]  ds_word_t;
    typedef logic [DS_CNT_W-1:0] ds_cnt_t;

    typedef struct packed {
        logic data;
        logic strobe;
    } ds_pair_t;

    // bits moved per system tick for a speed code
    function automatic ds_cnt_t ds_lanes(ds_speed_e s);
        case (s)
            SPD_HIGH: return ds_cnt_t'(DS_WMAX);
            SPD_MID:  return ds_cnt_t'(DS_WMAX / 2);
            default:  return ds_cnt_t'(DS_WMAX / 4);
        endcase
    endfunction

    // phase bits that must all be set for a bit slot
    function automatic logic [DS_PH_W-1:0] ds_slot_mask(ds_speed_e s);
        int unsigned n;
        n = int'(ds_lanes(s));
        return DS_PH_W'(DS_WMAX / n - 1);
    endfunction

    // keep only the low lanes of a word
    function automatic ds_word_t ds_keep(ds_word_t w, ds_speed_e s);
        int unsigned n;
        n = int'(ds_lanes(s));
        return w & ~(ds_word_t'('1) << n);
    endfunction

    // move the live lanes to the top so the MSB leaves first
    function automatic ds_word_t ds_align(ds_word_t w, ds_speed_e s);
        int unsigned n;
        n = int'(ds_lanes(s));
        return ds_keep(w, s) << (DS_WMAX - n);
    endfunction

endpackage

// File: rtl/ds_timebase.sv
module ds_timebase
    import ds_link_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ds_speed_e spd,
    output logic      sys_tick,
    output logic      bit_tick
);

    logic [DS_PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign sys_tick = (phase == DS_PH_W'(DS_WMAX - 1));
    assign bit_tick = ((phase & ds_slot_mask(spd)) == ds_slot_mask(spd));

endmodule

// File: rtl/ds_tx_path.sv
module ds_tx_path
    import ds_link_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sys_tick,
    input  logic      bit_tick,
    input  logic      tx_req,
    input  logic      rx_busy,
    input  ds_speed_e spd_in,
    input  ds_word_t  word_in,
    output ds_speed_e spd_q,
    output ds_pair_t  line,
    output logic      drive,
    output logic      active
);

    ds_word_t shreg;
    logic     start;
    logic     next_bit;

    assign start    = sys_tick && tx_req && !active && !rx_busy;
    assign next_bit = shreg[DS_WMAX-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            line   <= '0;
            drive  <= 1'b0;
            active <= 1'b0;
            spd_q  <= SPD_LOW;
        end else begin
            if (bit_tick && active) begin
                line.data   <= next_bit;
                line.strobe <= line.strobe ^ (next_bit == line.data);
                shreg       <= shreg << 1;
            end
            if (sys_tick) begin
                if (start) begin
                    spd_q  <= spd_in;
                    active <= 1'b1;
                    drive  <= 1'b1;
                    shreg  <= ds_align(word_in, spd_in);
                end else if (active && tx_req) begin
                    shreg <= ds_align(word_in, spd_q);
                end else if (active) begin
                    active <= 1'b0;
                end else if (drive) begin
                    drive <= 1'b0;
                    line  <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/ds_rx_path.sv
module ds_rx_path
    import ds_link_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_req,
    input  logic      tx_busy,
    input  ds_speed_e spd_in,
    input  ds_pair_t  line_in,
    output logic      push,
    output ds_word_t  push_word,
    output logic      active
);

    ds_pair_t  smp;
    logic      x_prev;
    ds_speed_e spd_q;
    ds_cnt_t   cnt;
    ds_word_t  acc;
    logic      evt;
    logic      last;

    assign evt       = active && ((smp.data ^ smp.strobe) != x_prev);
    assign last      = (cnt == ds_lanes(spd_q) - ds_cnt_t'(1));
    assign push      = evt && last;
    assign push_word = ds_keep({acc[DS_WMAX-2:0], smp.data}, spd_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp    <= '0;
            x_prev <= 1'b0;
            spd_q  <= SPD_LOW;
            cnt    <= '0;
            acc    <= '0;
            active <= 1'b0;
        end else begin
            smp    <= line_in;
            x_prev <= smp.data ^ smp.strobe;
            if (!active) begin
                if (rx_req && !tx_busy) begin
                    active <= 1'b1;
                    spd_q  <= spd_in;
                    cnt    <= '0;
                    acc    <= '0;
                end
            end else if (!rx_req) begin
                active <= 1'b0;
            end else if (evt) begin
                acc <= {acc[DS_WMAX-2:0], smp.data};
                cnt <= last ? '0 : cnt + ds_cnt_t'(1);
            end
        end
    end

endmodule

// File: rtl/ds_word_buf.sv
module ds_word_buf
    import ds_link_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  ds_word_t wdata,
    input  logic     rd_tick,
    output ds_word_t out_word,
    output logic     out_valid,
    output logic     full
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = AW + 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    ds_word_t        mem [DEPTH];
    logic [AW-1:0]   wp;
    logic [AW-1:0]   rp;
    logic [CW-1:0]   count;
    logic            empty;
    logic            pop;
    logic            push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign pop     = rd_tick && !empty;
    assign push_ok = wr && (!full || pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= '0;
            end
            wp        <= '0;
            rp        <= '0;
            count     <= '0;
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            if (push_ok) begin
                mem[wp] <= wdata;
                wp      <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
            end
            if (pop) begin
                rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
            end
            case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (rd_tick) begin
                out_valid <= !empty;
                out_word  <= empty ? '0 : mem[rp];
            end
        end
    end

endmodule

// File: rtl/ds_link.sv
module ds_link
    import ds_link_pkg::*;
#(
    parameter int unsigned BUF_DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         spd_i,
    input  logic               tx_en_i,
    input  logic [DS_WMAX-1:0] tx_data_i,
    output logic               tx_drive_o,
    output logic               tpa_o,
    output logic               tpb_o,
    input  logic               rx_en_i,
    input  logic               tpa_i,
    input  logic               tpb_i,
    output logic               rx_valid_o,
    output logic [DS_WMAX-1:0] rx_word_o,
    output logic               sys_tick_o
);

    ds_speed_e spd_sel;
    ds_speed_e tx_spd;
    logic      sys_tick;
    logic      bit_tick;
    logic      tx_active;
    logic      tx_drive;
    ds_pair_t  tx_line;
    ds_pair_t  rx_line;
    logic      rx_active;
    logic      rx_push;
    ds_word_t  rx_push_word;
    logic      buf_full;
    ds_word_t  buf_word;
    logic      buf_valid;

    assign spd_sel = ds_speed_e'(spd_i);
    // receive direction: A carries data, B carries strobe
    assign rx_line = ds_pair_t'({tpa_i, tpb_i});

    ds_timebase u_timebase (
        .clk      (clk),
        .rst      (rst),
        .spd      (tx_spd),
        .sys_tick (sys_tick),
        .bit_tick (bit_tick)
    );

    ds_tx_path u_tx (
        .clk      (clk),
        .rst      (rst),
        .sys_tick (sys_tick),
        .bit_tick (bit_tick),
        .tx_req   (tx_en_i),
        .rx_busy  (rx_active || rx_en_i),
        .spd_in   (spd_sel),
        .word_in  (tx_data_i),
        .spd_q    (tx_spd),
        .line     (tx_line),
        .drive    (tx_drive),
        .active   (tx_active)
    );

    ds_rx_path u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_req    (rx_en_i),
        .tx_busy   (tx_drive),
        .spd_in    (spd_sel),
        .line_in   (rx_line),
        .push      (rx_push),
        .push_word (rx_push_word),
        .active    (rx_active)
    );

    ds_word_buf #(
        .DEPTH (BUF_DEPTH)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr        (rx_push),
        .wdata     (rx_push_word),
        .rd_tick   (sys_tick),
        .out_word  (buf_word),
        .out_valid (buf_valid),
        .full      (buf_full)
    );

    // transmit direction: B carries data, A carries strobe
    assign tpb_o      = tx_line.data;
    assign tpa_o      = tx_line.strobe;
    assign tx_drive_o = tx_drive;
    assign rx_valid_o = buf_valid;
    assign rx_word_o  = buf_word;
    assign sys_tick_o = sys_tick;

endmodule

// File: rtl/ds_link_chk.sv
module ds_link_chk
    import ds_link_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sys_tick,
    input logic      tx_drive,
    input logic      tpa,
    input logic      tpb,
    input logic      tx_active,
    input ds_speed_e tx_spd,
    input logic      rx_active,
    input logic      rx_push,
    input logic      buf_full,
    input logic      rx_valid,
    input ds_word_t  rx_word
);

    AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(tx_drive && rx_active)); // R10

    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
        !tx_drive |-> (!tpa && !tpb)); // R5

    AST_ONE_LINE_MOVES: assert property (@(posedge clk) disable iff (rst)
        (tx_drive && $past(tx_drive)) |-> !((tpa != $past(tpa)) && (tpb != $past(tpb)))); // R3

    AST_SPEED_HELD: assert property (@(posedge clk) disable iff (rst)
        (tx_active && $past(tx_active)) |-> $stable(tx_spd)); // R6

    AST_RX_OUT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$past(sys_tick) |-> ($stable(rx_valid) && $stable(rx_word))); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (rx_push && buf_full) |-> sys_tick); // R7

endmodule

bind ds_link ds_link_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sys_tick  (sys_tick),
    .tx_drive  (tx_drive),
    .tpa       (tpa_o),
    .tpb       (tpb_o),
    .tx_active (tx_active),
    .tx_spd    (tx_spd),
    .rx_active (rx_active),
    .rx_push   (rx_push),
    .buf_full  (buf_full),
    .rx_valid  (rx_valid_o),
    .rx_word   (rx_word_o)
);

// File: tb/ds_link_tb.sv
module ds_link_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] spd_i = 2'd0;
    logic       tx_en_i = 1'b0;
    logic [7:0] tx_data_i = 8'h00;
    logic       tx_drive_o;
    logic       tpa_o;
    logic       tpb_o;
    logic       rx_en_i = 1'b0;
    logic       tpa_i = 1'b0;
    logic       tpb_i = 1'b0;
    logic       rx_valid_o;
    logic [7:0] rx_word_o;
    logic       sys_tick_o;

    int n_vec = 0;
    int n_bad = 0;

    bit         tx_q[$];
    logic [7:0] rx_q[$];
    int         tx_per = 1;

    always #10 clk = ~clk;

    ds_link u_dut (
        .clk        (clk),
        .rst        (rst),
        .spd_i      (spd_i),
        .tx_en_i    (tx_en_i),
        .tx_data_i  (tx_data_i),
        .tx_drive_o (tx_drive_o),
        .tpa_o      (tpa_o),
        .tpb_o      (tpb_o),
        .rx_en_i    (rx_en_i),
        .tpa_i      (tpa_i),
        .tpb_i      (tpb_i),
        .rx_valid_o (rx_valid_o),
        .rx_word_o  (rx_word_o),
        .sys_tick_o (sys_tick_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lanes_of(input logic [1:0] s);
        if (s == 2'd2) return 8;
        if (s == 2'd1) return 4;
        return 2;
    endfunction

    function automatic logic [7:0] pat(input int k, input logic [7:0] seed);
        case (k % 4)
            0:       return 8'hA5 ^ seed;
            1:       return 8'hFF ^ seed;
            2:       return 8'h00 ^ seed;
            default: return 8'h3C ^ seed;
        endcase
    endfunction

    task automatic wait_tick();
        do @(negedge clk); while (!sys_tick_o);
    endtask

    // transmit driver: queue expected bits MSB-first (R1, R2)
    task automatic tx_packet(input logic [1:0] s, input int nw, input logic [1:0] s_late,
                             input logic [7:0] seed);
        int w;
        w = lanes_of(s);
        wait_tick();
        tx_per = 8 / w;
        spd_i   = s;
        tx_en_i = 1'b1;
        for (int k = 0; k < nw; k++) begin
            logic [7:0] word;
            if (k > 0) begin
                wait_tick();
                spd_i = s_late;   // R6: ignored mid-packet
            end
            word = pat(k, seed);
            tx_data_i = word;
            for (int b = w - 1; b >= 0; b--) tx_q.push_back(word[b]);
        end
        wait_tick();
        tx_en_i = 1'b0;
        repeat (24) @(negedge clk);
        chk(tx_drive_o == 1'b0, "R5 drive released", int'(tx_drive_o), 0);
        chk(tx_q.size() == 0, "R1 all bits sent", tx_q.size(), 0);
    endtask

    // receive driver: build the line stream, queue expected words (R7)
    task automatic rx_packet(input logic [1:0] s, input int nw, input logic [1:0] s_late,
                             input bit extra, input logic [7:0] seed);
        int w;
        int per;
        bit pd;
        bit ps;
        w   = lanes_of(s);
        per = 8 / w;
        pd  = 1'b0;
        ps  = 1'b0;
        @(negedge clk);
        spd_i   = s;
        rx_en_i = 1'b1;
        @(negedge clk);
        spd_i = s_late;   // R9: ignored after start
        repeat (3) @(negedge clk);
        for (int k = 0; k < nw + (extra ? 1 : 0); k++) begin
            logic [7:0] word;
            int nb;
            word = pat(k, seed);
            nb   = (k < nw) ? w : 1;   // R11: trailing partial word
            if (k < nw) rx_q.push_back(word & 8'((1 << w) - 1));
            for (int b = w - 1; b >= w - nb; b--) begin
                bit sv;
                sv    = ps ^ (word[b] == pd);
                tpa_i = word[b];
                tpb_i = sv;
                pd    = word[b];
                ps    = sv;
                repeat (per) @(negedge clk);
            end
        end
        repeat (24) @(negedge clk);
        rx_en_i = 1'b0;
        @(negedge clk);
        tpa_i = 1'b0;
        tpb_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(rx_q.size() == 0, "R7 all words received", rx_q.size(), 0);
    endtask

    // transmit monitor
    int gap = -1;
    bit pd_m = 1'b0;
    bit ps_m = 1'b0;
    bit px_m = 1'b0;
    bit pdrv = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            bit x;
            x = tpa_o ^ tpb_o;
            if (tx_drive_o) begin
                gap++;
                if (x != px_m) begin
                    if (tx_q.size() == 0) begin
                        chk(1'b0, "R1 unexpected bit", 1, 0);
                    end else begin
                        bit e;
                        e = tx_q.pop_front();
                        chk(tpb_o == e, "R2 data bit", int'(tpb_o), int'(e));
                        chk(tpa_o == (ps_m ^ (e == pd_m)), "R3 strobe", int'(tpa_o),
                            int'(ps_m ^ (e == pd_m)));
                        chk(gap == tx_per, "R4 bit spacing", gap, tx_per);
                    end
                    pd_m = tpb_o;
                    ps_m = tpa_o;
                    gap  = 0;
                end
            end else begin
                gap  = -1;
                pd_m = 1'b0;
                ps_m = 1'b0;
                if (pdrv) begin
                    chk(!tpa_o && !tpb_o, "R5 lines idle", int'({tpa_o, tpb_o}), 0);
                    chk(tx_q.size() == 0, "R5 tail covers last bit", tx_q.size(), 0);
                end
            end
            px_m = x;
            pdrv = tx_drive_o;
        end
    end

    // receive monitor: one sample per system period (R8)
    always @(negedge clk) begin
        if (!rst && sys_tick_o && rx_valid_o) begin
            if (rx_q.size() == 0) begin
                chk(1'b0, "R8 R11 unexpected word", int'(rx_word_o), -1);
            end else begin
                logic [7:0] e;
                e = rx_q.pop_front();
                chk(rx_word_o == e, "R7 word value", int'(rx_word_o), int'(e));
            end
        end
    end

    initial begin
        #3000000;
        chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R12: reset state
        chk({tx_drive_o, tpa_o, tpb_o, rx_valid_o, sys_tick_o} == 5'b0, "R12 reset outputs",
            int'({tx_drive_o, tpa_o, tpb_o, rx_valid_o, sys_tick_o}), 0);
        chk(rx_word_o == 8'h00, "R12 reset word", int'(rx_word_o), 0);
        rst = 1'b0;
        // R12: tick period
        wait_tick();
        begin
            int c;
            c = 0;
            do begin @(negedge clk); c++; end while (!sys_tick_o);
            chk(c == 8, "R12 tick period", c, 8);
        end

        tx_packet(2'd2, 3, 2'd2, 8'h00);   // R1 top speed
        tx_packet(2'd1, 4, 2'd1, 8'h5A);   // R1 middle speed
        tx_packet(2'd0, 4, 2'd2, 8'h81);   // R6 speed change ignored
        tx_packet(2'd3, 2, 2'd3, 8'h0F);   // R1 reserved code behaves as low

        rx_packet(2'd2, 4, 2'd2, 1'b0, 8'h00);  // R7 top speed
        rx_packet(2'd0, 4, 2'd1, 1'b1, 8'h66);  // R9 held speed, R11 partial dropped
        rx_packet(2'd1, 3, 2'd1, 1'b0, 8'hC3);  // R11 next packet realigned

        // R11: line activity with receive disabled
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            tpa_i = i[0];
            tpb_i = i[2];
        end
        tpa_i = 1'b0;
        tpb_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(rx_valid_o == 1'b0, "R11 idle lines ignored", int'(rx_valid_o), 0);

        // R10: receive mode blocks transmit
        @(negedge clk);
        rx_en_i = 1'b1;
        wait_tick();
        spd_i     = 2'd2;
        tx_en_i   = 1'b1;
        tx_data_i = 8'hF0;
        for (int i = 0; i < 3; i++) begin
            wait_tick();
            chk(tx_drive_o == 1'b0, "R10 no transmit while receiving", int'(tx_drive_o), 0);
        end
        tx_en_i = 1'b0;
        rx_en_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(rx_valid_o == 1'b0, "R10 no stray word", int'(rx_valid_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule